// File: doc/BRIEF.md
# Two-Level Nested Priority Interrupt Controller

This block gathers interrupt requests from peripherals and presents them to a processor through one interrupt line. Two identical eight-line controller units sit inside it. The primary unit talks to the processor. The secondary unit's interrupt output takes the place of primary input 2, so the pair serves fifteen request lines. Each unit captures requests, masks them, and selects the most urgent one. It raises the interrupt only when that request outranks everything already in service. When the processor sends an acknowledge strobe, the block drives an 8-bit vector for that request onto the data bus.

Software programs each unit through a small write port. Each unit has a mask, a vector base, and an end-of-interrupt command. A handler for a cascaded line must issue end-of-interrupt to the secondary and then to the primary. Overall line 9, which is secondary line 1, stands in for the old line-2 source. It is serviced through the link slot like every other secondary line.

Top module: `irq_ctrl_cascade`

## Requirements
- R1: Reset state: irq_o and bus_oe_o are low, every line is unmasked, and both vector bases are zero. An acknowledge with nothing pending returns the spurious vector {base, 3'b111}, which is 8'h07 after reset.
- R2: A request bit that is high at a rising edge is held pending until it is acknowledged, even if the bit then drops. For a primary line, irq_o is high from that same edge onward.
- R3: Priority: a lower line number wins. The eight secondary lines (req_i[15:8]) all rank in the slot of primary line 2, below lines 0 and 1 and above lines 3 to 7.
- R4: While inta_i is high, bus_oe_o is high and bus_o = {base[4:0], line[2:0]} of the winning request. The winning line then becomes in-service and stops being pending. When inta_i is low, bus_oe_o is low.
- R5: Mask register write (wr_reg_i = 0): data bit i masks line i of the selected unit (wr_sec_i = 0 selects the primary, 1 the secondary). A masked pending line raises no interrupt. Clearing the mask bit later raises the interrupt.
- R6: Nesting: while a line is in service, pending lines of equal or lower priority do not raise irq_o, and a pending line of higher priority does.
- R7: End-of-interrupt write (wr_reg_i = 2) clears the highest-priority in-service bit of the selected unit. Requests held back by that bit then raise irq_o.
- R8: Cascade: a secondary line reaches the primary through its link input one cycle after capture. On acknowledge, the secondary supplies the vector {secondary base, secondary line}. req_i[2] has no effect.
- R9: Overall line 9 (secondary line 1) is the line-2 replacement. It yields the vector {secondary base, 3'b001} and occupies the primary's line-2 service slot, so primary lines 0 and 1 can still nest above it.
- R10: Base register write (wr_reg_i = 1): data bits [7:3] become the selected unit's vector base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Request lines; bit 2 is replaced by the link |
| irq_o | output | 1 | Interrupt to the processor |
| inta_i | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| wr_en_i | input | 1 | Register write strobe |
| wr_sec_i | input | 1 | Write target: 0 primary, 1 secondary |
| wr_reg_i | input | 2 | 0 mask, 1 vector base, 2 end-of-interrupt |
| wr_data_i | input | 8 | Write data |
| bus_o | output | 8 | Vector driven during acknowledge |
| bus_oe_o | output | 1 | Bus drive enable |

## Verification
The hardest state to reach is a three-deep nesting that spans both units. In it, the secondary holds a line in service, the primary holds its link slot in service, and a primary line above the link interrupts on top of both. The stimulus gets there by pulsing line 9, waiting one extra cycle for the link, and acknowledging it. It then pulses line 1 and acknowledges again. It then unwinds with three end-of-interrupt writes in the required order, and the interrupt line must stay quiet at the end. A second nested sequence inside one unit checks that end-of-interrupt releases only the highest in-service level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_BASE = 2'd1,
    REG_EOI  = 2'd2
  } irqc_reg_e;
endpackage

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
  import irqc_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int BASE_W = 5,
  localparam int IDX_W  = $clog2(LINES),
  localparam int DATA_W = BASE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  req_i,
  input  logic              ack_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_reg_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] vec_o,
  output logic [LINES-1:0]  isr_o,
  output logic              ack_fire_o
);
  function automatic logic [LINES-1:0] line_bit(input logic [IDX_W-1:0] idx);
    return LINES'(1) << idx;
  endfunction

  function automatic logic [LINES-1:0] at_or_above(input logic [IDX_W-1:0] idx);
    return (LINES'(1) << (idx + 1'b1)) - 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] make_vec(input logic [BASE_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return {base, idx};
  endfunction

  logic [LINES-1:0]  irr_q, isr_q, mask_q;
  logic [BASE_W-1:0] base_q;
  logic [LINES-1:0]  cand;
  logic              cand_any, isr_any;
  logic [IDX_W-1:0]  cand_idx, isr_idx;
  logic              ack_fire, eoi_fire;
  logic [LINES-1:0]  set_isr, clr_isr;

  assign cand = irr_q & ~mask_q;

  irqc_first_set #(.N(LINES)) u_cand (.vec_i(cand),  .any_o(cand_any), .idx_o(cand_idx));
  irqc_first_set #(.N(LINES)) u_isr  (.vec_i(isr_q), .any_o(isr_any),  .idx_o(isr_idx));

  assign irq_o      = cand_any && (!isr_any || (cand_idx < isr_idx));
  assign ack_fire   = ack_i && irq_o;
  assign eoi_fire   = wr_en_i && (irqc_reg_e'(wr_reg_i) == REG_EOI) && isr_any;
  assign set_isr    = ack_fire ? line_bit(cand_idx) : '0;
  assign clr_isr    = eoi_fire ? line_bit(isr_idx) : '0;
  assign idx_o      = cand_idx;
  assign vec_o      = make_vec(base_q, irq_o ? cand_idx : {IDX_W{1'b1}});
  assign isr_o      = isr_q;
  assign ack_fire_o = ack_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      base_q <= '0;
    end else begin
      irr_q <= (irr_q | req_i) & ~set_isr;
      isr_q <= (isr_q & ~clr_isr) | set_isr;
      if (wr_en_i && irqc_reg_e'(wr_reg_i) == REG_MASK) mask_q <= wr_data_i[LINES-1:0];
      if (wr_en_i && irqc_reg_e'(wr_reg_i) == REG_BASE) base_q <= wr_data_i[DATA_W-1 -: BASE_W];
    end
  end

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> isr_q[$past(cand_idx)]); // R6
  AST_ACK_RETIRES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !req_i[cand_idx]) |=> !irr_q[$past(cand_idx)]); // R4
  AST_IRQ_OUTRANKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((isr_q & at_or_above(cand_idx)) == '0)); // R6
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !ack_fire) |=> ($countones(isr_q) + 1 == $past($countones(isr_q)))); // R7
  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_q[0] && !ack_fire) |=> irr_q[0]); // R2
endmodule

// File: rtl/irq_ctrl_cascade.sv
module irq_ctrl_cascade #(
  parameter int LINES     = 8,
  parameter int BASE_W    = 5,
  parameter int LINK_LINE = 2,
  localparam int IDX_W  = $clog2(LINES),
  localparam int DATA_W = BASE_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LINES-1:0] req_i,
  output logic               irq_o,
  input  logic               inta_i,
  input  logic               wr_en_i,
  input  logic               wr_sec_i,
  input  logic [1:0]         wr_reg_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  bus_o,
  output logic               bus_oe_o
);
  logic [LINES-1:0]  p_req, p_isr, s_isr;
  logic              p_irq, s_irq, p_ack_fire, s_ack_fire;
  logic [IDX_W-1:0]  p_idx, s_idx;
  logic [DATA_W-1:0] p_vec, s_vec;
  logic              link_sel, s_ack;

  always_comb begin
    p_req            = req_i[LINES-1:0];
    p_req[LINK_LINE] = s_irq;
  end

  assign link_sel = p_irq && (p_idx == IDX_W'(LINK_LINE));
  assign s_ack    = inta_i && link_sel;

  irqc_unit #(.LINES(LINES), .BASE_W(BASE_W)) u_primary (
    .clk(clk), .rst_n(rst_n), .req_i(p_req), .ack_i(inta_i),
    .wr_en_i(wr_en_i && !wr_sec_i), .wr_reg_i(wr_reg_i), .wr_data_i(wr_data_i),
    .irq_o(p_irq), .idx_o(p_idx), .vec_o(p_vec), .isr_o(p_isr), .ack_fire_o(p_ack_fire)
  );

  irqc_unit #(.LINES(LINES), .BASE_W(BASE_W)) u_secondary (
    .clk(clk), .rst_n(rst_n), .req_i(req_i[2*LINES-1:LINES]), .ack_i(s_ack),
    .wr_en_i(wr_en_i && wr_sec_i), .wr_reg_i(wr_reg_i), .wr_data_i(wr_data_i),
    .irq_o(s_irq), .idx_o(s_idx), .vec_o(s_vec), .isr_o(s_isr), .ack_fire_o(s_ack_fire)
  );

  assign irq_o    = p_irq;
  assign bus_oe_o = inta_i;
  assign bus_o    = link_sel ? s_vec : p_vec;

  AST_LINK_SLOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack_fire |=> (p_isr[LINK_LINE] && (s_isr != '0))); // R8
  AST_SEC_LINE_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_i && link_sel && s_irq) |-> (bus_o[IDX_W-1:0] == s_idx)); // R8
  AST_PRIMARY_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
    p_ack_fire |=> (p_isr != '0)); // R4
endmodule

// File: tb/irq_ctrl_cascade_bench.sv
module irq_ctrl_cascade_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0;
  logic        inta_i = 1'b0, wr_en_i = 1'b0, wr_sec_i = 1'b0;
  logic [1:0]  wr_reg_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        irq_o, bus_oe_o;
  logic [7:0]  bus_o;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [4:0] p_base = '0, s_base = '0;

  always #2.5 clk = ~clk;

  irq_ctrl_cascade u_irq_ctrl_cascade (.*);

  function automatic logic [7:0] vec_of(input logic [4:0] base, input int line);
    return (8'(base) << 3) + 8'(line);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_oe_o) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R4: unexpected bus drive actual %0h expected none", bus_o);
      end else begin
        check(tag_q.pop_front(), bus_o, exp_q.pop_front());
      end
    end else if (rst_n && inta_i == 1'b0) begin
      check("R4 bus idle", {7'd0, bus_oe_o}, 8'd0);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input logic [15:0] lines);
    step(); req_i = lines;
    step(); req_i = '0;
  endtask

  task automatic ack(input string tag, input logic [7:0] exp);
    step(); exp_q.push_back(exp); tag_q.push_back(tag); inta_i = 1'b1;
    step(); inta_i = 1'b0;
  endtask

  task automatic wr(input logic sec, input logic [1:0] r, input logic [7:0] d);
    step(); wr_en_i = 1'b1; wr_sec_i = sec; wr_reg_i = r; wr_data_i = d;
    step(); wr_en_i = 1'b0;
  endtask

  task automatic irq_is(input string tag, input logic exp);
    check(tag, {7'd0, irq_o}, {7'd0, exp});
  endtask

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    irq_is("R1 reset irq", 1'b0);
    check("R1 reset oe", {7'd0, bus_oe_o}, 8'd0);
    ack("R1 spurious vector", 8'h07);

    p_base = 5'b00100; s_base = 5'b01110;
    wr(1'b0, 2'd1, {p_base, 3'b000});
    wr(1'b1, 2'd1, {s_base, 3'b101});  // R10 low bits ignored

    pulse(16'h0020);
    irq_is("R2 capture line5", 1'b1);
    ack("R4 vector line5", vec_of(p_base, 5));
    irq_is("R4 retired", 1'b0);
    wr(1'b0, 2'd2, 8'h00);

    pulse(16'h004A);
    ack("R3 line1 first", vec_of(p_base, 1));
    irq_is("R6 lower held", 1'b0);
    wr(1'b0, 2'd2, 8'h00);
    ack("R3 line3 second", vec_of(p_base, 3));
    wr(1'b0, 2'd2, 8'h00);
    ack("R3 line6 last", vec_of(p_base, 6));
    wr(1'b0, 2'd2, 8'h00);
    irq_is("R7 all done", 1'b0);

    pulse(16'h1010); step();
    ack("R3 secondary above line4", vec_of(s_base, 4));
    irq_is("R6 line4 below link", 1'b0);
    wr(1'b1, 2'd2, 8'h00);
    irq_is("R7 primary still holds link", 1'b0);
    wr(1'b0, 2'd2, 8'h00);
    irq_is("R7 line4 released", 1'b1);
    ack("R3 line4 after", vec_of(p_base, 4));
    wr(1'b0, 2'd2, 8'h00);

    pulse(16'h0004); step(); step();
    irq_is("R8 req bit2 ignored", 1'b0);

    pulse(16'h0200);
    irq_is("R8 link lags a cycle", 1'b0);
    step();
    irq_is("R8 link raised", 1'b1);
    ack("R9 line9 vector", vec_of(s_base, 1));
    pulse(16'h0002);
    irq_is("R9 line1 nests above slot2", 1'b1);
    ack("R9 nested line1", vec_of(p_base, 1));
    wr(1'b0, 2'd2, 8'h00);
    wr(1'b1, 2'd2, 8'h00);
    wr(1'b0, 2'd2, 8'h00);
    irq_is("R9 unwound", 1'b0);

    wr(1'b0, 2'd0, 8'h08);
    pulse(16'h0008);
    irq_is("R5 masked quiet", 1'b0);
    wr(1'b0, 2'd0, 8'h00);
    irq_is("R5 unmask raises", 1'b1);
    ack("R5 line3 after unmask", vec_of(p_base, 3));
    wr(1'b0, 2'd2, 8'h00);

    pulse(16'h0040);
    ack("R6 line6", vec_of(p_base, 6));
    pulse(16'h0010);
    irq_is("R6 higher nests", 1'b1);
    ack("R6 line4 nested", vec_of(p_base, 4));
    pulse(16'h0020);
    irq_is("R6 line5 below line4", 1'b0);
    wr(1'b0, 2'd2, 8'h00);
    irq_is("R7 eoi clears top level only", 1'b1);
    ack("R7 line5", vec_of(p_base, 5));
    wr(1'b0, 2'd2, 8'h00);
    wr(1'b0, 2'd2, 8'h00);
    irq_is("R7 empty", 1'b0);

    p_base = 5'b10101;
    wr(1'b0, 2'd1, 8'hA8);
    pulse(16'h0080);
    ack("R10 new base", vec_of(p_base, 7));
    wr(1'b0, 2'd2, 8'h00);

    wr(1'b1, 2'd0, 8'h01);
    pulse(16'h0100); step(); step();
    irq_is("R5 secondary mask", 1'b0);

    step();
    check("R4 queue drained", 8'(exp_q.size()), 8'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule